// File: doc/BRIEF.md
# Handshaked ALU Computation Unit

This unit sits between an instruction issue stage and a register file and runs one small integer operation at a time. An issue pulse, together with an operation descriptor, claims the unit. The unit then asks for each source operand it needs on its own read port, using a release/go handshake. It takes the operand value on the cycle the port is granted, computes the result and asks for a write slot. A single write grant hands the result over and frees the unit.

Operands are `DATA_W` bits wide (16 by default), and `NUM_SRC` selects two or three source ports. The operation is a pass-through (NOP) of operand A or an ADD of all operands, both modulo 2^DATA_W. The descriptor can zero operand A, bitwise-invert operand A (after zeroing), or replace operand B with an immediate. A skip mask, sampled at issue and held steady by the issuer while the unit is busy, removes ports from the read phase altogether. A port that is not read contributes zero, unless it is operand B replaced by the immediate.

The controller has four states. IDLE moves to READ when an issue pulse arrives (transition *accept*). READ moves to EXEC once no read is pending (transition *reads_done*). EXEC moves to WRITE unconditionally, loading the result register (transition *latch_result*). WRITE returns to IDLE when the write is granted (transition *retire*).

Top module: `compute_unit`

## Requirements
- R1: After reset, busy_o, every rd_rel_o bit and wr_rel_o are low, and they stay low for as long as the unit is idle.
- R2: An issue_i pulse while idle is accepted on that clock edge. busy_o and the read releases of the needed ports are high from the following cycle and never on the issue cycle itself.
- R3: A raised rd_rel_o bit stays high through any number of stall cycles until its rd_go_i bit is seen high at a clock edge.
- R4: A port's operand is taken from its src_i slice (port i at bits i*DATA_W upward) at the edge where its rd_go_i and rd_rel_o are both high, and that release is low from the next cycle. Ports complete in any order, and rd_go_i on a port whose release is low has no effect.
- R5: With imm_vld_i set at issue, port 1 is never released and imm_i takes operand B's place; for example A=5 with immediate 8 under ADD gives 13.
- R6: With zero_a_i and imm_vld_i both set at issue, no read release rises at all and ADD returns the immediate value.
- R7: With three source ports, port 2 is released only once ports 0 and 1 have both completed or were not needed.
- R8: wr_rel_o rises after the second clock edge following the last read grant edge (or the accepting edge when nothing is read). data_o holds the result and stays stable while wr_rel_o is high. A wr_go_i edge ends the operation, so busy_o and wr_rel_o are low from the next cycle. No read release is high while wr_rel_o is high.
- R9: op_kind_i = 0 (NOP) returns operand A as seen after zeroing and inversion; A=5 returns 5 and A=9 returns 9.
- R10: op_kind_i = 1 (ADD) returns the sum of all operands modulo 2^DATA_W. With inv_a_i set, operand A is bitwise inverted after zero_a_i is applied.
- R11: issue_i while busy is ignored: the running operation's result is not altered and no new read phase starts after it retires.
- R12: A set bit i of rd_skip_i at issue keeps port i unreleased for that operation, and its operand reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One-cycle request to start an operation |
| op_kind_i | input | 1 | 0 = NOP (pass A), 1 = ADD |
| inv_a_i | input | 1 | Invert operand A bitwise |
| zero_a_i | input | 1 | Use zero for operand A, no read of port 0 |
| imm_vld_i | input | 1 | Use imm_i for operand B, no read of port 1 |
| imm_i | input | DATA_W | Immediate value |
| rd_skip_i | input | NUM_SRC | Ports left out of the read phase; held while busy |
| busy_o | output | 1 | Unit holds an operation |
| rd_rel_o | output | NUM_SRC | Per-port read release |
| rd_go_i | input | NUM_SRC | Per-port read grant |
| src_i | input | NUM_SRC*DATA_W | Operand values, port i at bits i*DATA_W upward |
| wr_rel_o | output | 1 | Result ready for writing |
| wr_go_i | input | 1 | Write grant |
| data_o | output | DATA_W | Result value |

## Verification
Each release is registered, so the bench drives on the falling edge and reads every output on the next falling edge. A read release is due one edge after the accepting edge, and it drops one edge after its grant. The write release comes on the third edge counting from the last grant or accepting edge, and the bench checks it low on the two falling edges before that. busy_o is checked low one edge after the write grant. The sweep covers every combination of operation, invert, zero-A, immediate and skip mask, with stall lengths, grant orders and spurious grants on unreleased ports varied; the expected result comes from arithmetic on the driven operands.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic {
        ALU_NOP = 1'b0,
        ALU_ADD = 1'b1
    } alu_op_e;

    typedef struct packed {
        alu_op_e kind;
        logic    inv_a;
        logic    zero_a;
        logic    imm_vld;
    } op_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } cu_state_e;

endpackage

// File: rtl/cu_read_port.sv
module cu_read_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              need_i,
    input  logic              allow_i,
    input  logic              go_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rel_o,
    output logic              pend_o,
    output logic [DATA_W-1:0] val_o
);

    logic              pend_q;
    logic [DATA_W-1:0] val_q;

    assign rel_o  = pend_q & allow_i;
    assign pend_o = pend_q;
    assign val_o  = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            val_q  <= '0;
        end else if (arm_i) begin
            pend_q <= need_i;
            val_q  <= '0;
        end else if (rel_o && go_i) begin
            pend_q <= 1'b0;
            val_q  <= data_i;
        end
    end

endmodule

// File: rtl/cu_fsm.sv
module cu_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic reads_left_i,
    input  logic wr_go_i,
    output logic accept_o,
    output logic busy_o,
    output logic read_ph_o,
    output logic exec_o,
    output logic write_ph_o
);
    import cu_pkg::*;

    cu_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (issue_i)       state_d = ST_READ;
            ST_READ:  if (!reads_left_i) state_d = ST_EXEC;
            ST_EXEC:                     state_d = ST_WRITE;
            ST_WRITE: if (wr_go_i)       state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o   = 1'b0;
        busy_o     = 1'b1;
        read_ph_o  = 1'b0;
        exec_o     = 1'b0;
        write_ph_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = issue_i;
            end
            ST_READ:  read_ph_o  = 1'b1;
            ST_EXEC:  exec_o     = 1'b1;
            ST_WRITE: write_ph_o = 1'b1;
            default:  busy_o     = 1'b0;
        endcase
    end

endmodule

// File: rtl/cu_alu.sv
module cu_alu #(
    parameter int DATA_W  = 16,
    parameter int NUM_SRC = 2
) (
    input  cu_pkg::op_flags_t            flags_i,
    input  logic [DATA_W-1:0]            imm_i,
    input  logic [NUM_SRC*DATA_W-1:0]    opnd_i,
    output logic [DATA_W-1:0]            res_o
);
    import cu_pkg::*;

    logic [DATA_W-1:0] a_pre, a_eff, b_eff, c_eff;

    assign a_pre = flags_i.zero_a ? '0 : opnd_i[0 +: DATA_W];
    assign a_eff = flags_i.inv_a ? ~a_pre : a_pre;
    assign b_eff = flags_i.imm_vld ? imm_i : opnd_i[DATA_W +: DATA_W];

    generate
        if (NUM_SRC > 2) begin : g_third
            assign c_eff = opnd_i[2*DATA_W +: DATA_W];
        end else begin : g_no_third
            assign c_eff = '0;
        end
    endgenerate

    always_comb begin
        res_o = a_eff;
        unique case (flags_i.kind)
            ALU_ADD: res_o = a_eff + b_eff + c_eff;
            ALU_NOP: res_o = a_eff;
            default: res_o = a_eff;
        endcase
    end

endmodule

// File: rtl/compute_unit.sv
module compute_unit #(
    parameter int DATA_W  = 16,
    parameter int NUM_SRC = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        issue_i,
    input  logic                        op_kind_i,
    input  logic                        inv_a_i,
    input  logic                        zero_a_i,
    input  logic                        imm_vld_i,
    input  logic [DATA_W-1:0]           imm_i,
    input  logic [NUM_SRC-1:0]          rd_skip_i,
    output logic                        busy_o,
    output logic [NUM_SRC-1:0]          rd_rel_o,
    input  logic [NUM_SRC-1:0]          rd_go_i,
    input  logic [NUM_SRC*DATA_W-1:0]   src_i,
    output logic                        wr_rel_o,
    input  logic                        wr_go_i,
    output logic [DATA_W-1:0]           data_o
);
    import cu_pkg::*;

    localparam int SRC_W = NUM_SRC * DATA_W;

    logic               accept, read_ph, exec_en, write_ph;
    logic [NUM_SRC-1:0] need, pend, allow;
    logic [SRC_W-1:0]   opnd_flat;
    op_flags_t          flags_q;
    logic [DATA_W-1:0]  imm_q, res_d, res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '{kind: ALU_NOP, inv_a: 1'b0, zero_a: 1'b0, imm_vld: 1'b0};
            imm_q   <= '0;
        end else if (accept) begin
            flags_q <= '{kind: alu_op_e'(op_kind_i), inv_a: inv_a_i,
                         zero_a: zero_a_i, imm_vld: imm_vld_i};
            imm_q   <= imm_i;
        end
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_port
            if (i == 0) begin : g_need_a
                assign need[i] = ~zero_a_i & ~rd_skip_i[i];
            end else if (i == 1) begin : g_need_b
                assign need[i] = ~imm_vld_i & ~rd_skip_i[i];
            end else begin : g_need_c
                assign need[i] = ~rd_skip_i[i];
            end

            if (i < 2) begin : g_allow_first
                assign allow[i] = read_ph;
            end else begin : g_allow_late
                assign allow[i] = read_ph & ~(|pend[1:0]);
            end

            cu_read_port #(.DATA_W(DATA_W)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .arm_i   (accept),
                .need_i  (need[i]),
                .allow_i (allow[i]),
                .go_i    (rd_go_i[i]),
                .data_i  (src_i[i*DATA_W +: DATA_W]),
                .rel_o   (rd_rel_o[i]),
                .pend_o  (pend[i]),
                .val_o   (opnd_flat[i*DATA_W +: DATA_W])
            );
        end
    endgenerate

    cu_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue_i),
        .reads_left_i (|pend),
        .wr_go_i      (wr_go_i),
        .accept_o     (accept),
        .busy_o       (busy_o),
        .read_ph_o    (read_ph),
        .exec_o       (exec_en),
        .write_ph_o   (write_ph)
    );

    cu_alu #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_alu (
        .flags_i (flags_q),
        .imm_i   (imm_q),
        .opnd_i  (opnd_flat),
        .res_o   (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       res_q <= '0;
        else if (exec_en) res_q <= res_d;
    end

    assign wr_rel_o = write_ph;
    assign data_o   = res_q;

endmodule

// File: rtl/cu_checker.sv
module cu_checker #(
    parameter int DATA_W  = 16,
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_i,
    input logic               busy_o,
    input logic [NUM_SRC-1:0] rd_rel_o,
    input logic [NUM_SRC-1:0] rd_go_i,
    input logic               wr_rel_o,
    input logic               wr_go_i,
    input logic [DATA_W-1:0]  data_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_rel_o == '0 && !wr_rel_o));

    assert_issue_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && issue_i) |=> busy_o);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_rel
            assert_rel_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_rel_o[i] && !rd_go_i[i]) |=> rd_rel_o[i]);

            assert_rel_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_rel_o[i] && rd_go_i[i]) |=> !rd_rel_o[i]);
        end

        if (NUM_SRC > 2) begin : g_third
            assert_third_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rd_rel_o[2] |-> (rd_rel_o[1:0] == 2'b00));
        end
    endgenerate

    assert_write_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rel_o |-> (rd_rel_o == '0));

    assert_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && !wr_go_i) |=> (wr_rel_o && $stable(data_o)));

    assert_write_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && wr_go_i) |=> (!busy_o && !wr_rel_o));

    assert_busy_issue_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && issue_i && !wr_rel_o) |=> busy_o);

endmodule

bind compute_unit cu_checker #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_cu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .busy_o   (busy_o),
    .rd_rel_o (rd_rel_o),
    .rd_go_i  (rd_go_i),
    .wr_rel_o (wr_rel_o),
    .wr_go_i  (wr_go_i),
    .data_o   (data_o)
);

// File: tb/tb_compute_unit.sv
module tb_compute_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic          op_kind_i = 1'b0;
    logic          inv_a_i = 1'b0;
    logic          zero_a_i = 1'b0;
    logic          imm_vld_i = 1'b0;
    logic [W-1:0]  imm_i = '0;
    logic [NS-1:0] rd_skip_i = '0;
    logic          busy_o;
    logic [NS-1:0] rd_rel_o;
    logic [NS-1:0] rd_go_i = '0;
    logic [NS*W-1:0] src_i = '0;
    logic          wr_rel_o;
    logic          wr_go_i = 1'b0;
    logic [W-1:0]  data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    compute_unit #(.DATA_W(W), .NUM_SRC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_kind_i(op_kind_i),
        .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_vld_i(imm_vld_i),
        .imm_i(imm_i), .rd_skip_i(rd_skip_i), .busy_o(busy_o),
        .rd_rel_o(rd_rel_o), .rd_go_i(rd_go_i), .src_i(src_i),
        .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_op(input logic kind, input logic inv, input logic zro,
                          input logic immv, input logic [W-1:0] imm,
                          input logic [NS-1:0] skip, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W-1:0] c,
                          input int d0, input int d1, input int d2,
                          input logic spur, input logic poke);
        logic [NS-1:0] need, done, gone, seen, first;
        logic [W-1:0]  vals [NS];
        int            dly  [NS];
        int            waitc[NS];
        logic [W-1:0]  ea0, ea, eb, ec, exp_res, held;
        string         rtag;

        vals[0] = a; vals[1] = b; vals[2] = c;
        dly[0] = d0; dly[1] = d1; dly[2] = d2;
        for (int i = 0; i < NS; i++) waitc[i] = 0;
        need[0] = !zro && !skip[0];
        need[1] = !immv && !skip[1];
        need[2] = !skip[2];
        first = need & {~(need[0] | need[1]), 2'b11};

        ea0 = (zro || skip[0]) ? '0 : a;
        ea  = inv ? ~ea0 : ea0;
        eb  = immv ? imm : (skip[1] ? '0 : b);
        ec  = skip[2] ? '0 : c;
        exp_res = kind ? W'(ea + eb + ec) : ea;
        if (zro && immv)  rtag = "R6";
        else if (immv)    rtag = "R5";
        else if (skip != 0) rtag = "R12";
        else if (inv)     rtag = "R10";
        else if (!kind)   rtag = "R9";
        else              rtag = "R10";

        @(negedge clk);
        chk(!busy_o && rd_rel_o == 0 && !wr_rel_o, "R1 idle before issue",
            {busy_o, rd_rel_o, wr_rel_o}, 0);
        issue_i = 1'b1; op_kind_i = kind; inv_a_i = inv; zero_a_i = zro;
        imm_vld_i = immv; imm_i = imm; rd_skip_i = skip;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0; op_kind_i = ~kind; inv_a_i = ~inv; zero_a_i = ~zro;
        imm_vld_i = ~immv; imm_i = ~imm;
        chk(busy_o, "R2 busy after issue", busy_o, 1);
        chk(rd_rel_o == first, "R2 first releases", rd_rel_o, first);

        done = 0; gone = 0; seen = 0;
        while (done != need) begin
            for (int i = 0; i < NS; i++)
                if (gone[i]) chk(!rd_rel_o[i], "R4 release drops", rd_rel_o[i], 0);
            chk(!wr_rel_o, "R8 no write during reads", wr_rel_o, 0);
            chk(!rd_rel_o[2] || done[1:0] == need[1:0], "R7 third port order",
                rd_rel_o, done);
            gone = 0;
            for (int i = 0; i < NS; i++) begin
                if (!need[i]) begin
                    chk(!rd_rel_o[i],
                        (i == 0 && zro) ? "R6 no read of A" :
                        (i == 1 && immv) ? "R5 no read of B" : "R12 skipped port",
                        rd_rel_o[i], 0);
                end else if (!done[i]) begin
                    if (rd_rel_o[i]) begin
                        seen[i] = 1'b1;
                        if (waitc[i] >= dly[i]) begin
                            rd_go_i[i] = 1'b1;
                            src_i[i*W +: W] = vals[i];
                            done[i] = 1'b1;
                            gone[i] = 1'b1;
                        end else begin
                            waitc[i]++;
                        end
                    end else begin
                        chk(!seen[i], "R3 release held in stall", rd_rel_o[i], 1);
                        if (spur) begin
                            rd_go_i[i] = 1'b1;
                            src_i[i*W +: W] = W'(16'hDEAD ^ i);
                        end
                    end
                end
            end
            @(posedge clk);
            @(negedge clk);
            rd_go_i = '0;
            src_i = '0;
        end
        for (int i = 0; i < NS; i++)
            if (gone[i]) chk(!rd_rel_o[i], "R4 release drops", rd_rel_o[i], 0);

        chk(!wr_rel_o, "R8 write not yet due", wr_rel_o, 0);
        if (poke) begin
            issue_i = 1'b1; op_kind_i = 1'b1; inv_a_i = 1'b1; zero_a_i = 1'b0;
            imm_vld_i = 1'b1; imm_i = 16'h1234; rd_skip_i = '0;
        end
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0;
        rd_skip_i = skip;
        chk(!wr_rel_o, "R8 write not yet due", wr_rel_o, 0);
        @(posedge clk);
        @(negedge clk);
        chk(wr_rel_o, "R8 write release due", wr_rel_o, 1);
        chk(rd_rel_o == 0, "R8 no read with write", rd_rel_o, 0);
        chk(data_o == exp_res, poke ? "R11 result kept" : rtag, data_o, exp_res);
        held = data_o;
        @(posedge clk);
        @(negedge clk);
        chk(wr_rel_o && data_o == held, "R8 write held", {wr_rel_o, data_o}, {1'b1, held});
        wr_go_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_go_i = 1'b0;
        chk(!busy_o && !wr_rel_o, "R8 retire", {busy_o, wr_rel_o}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rd_rel_o == 0 && !busy_o, poke ? "R11 no late start" : "R1 idle after retire",
            {busy_o, rd_rel_o}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy_o && rd_rel_o == 0 && !wr_rel_o, "R1 reset state",
            {busy_o, rd_rel_o, wr_rel_o}, 0);
        rst_n = 1'b1;

        // directed values: immediate add, zero plus immediate, pass-through, wrap
        run_op(1'b1, 1'b0, 1'b0, 1'b1, 16'd8, 3'b100, 16'd5, 16'd2, 16'd0, 0, 0, 0, 1'b0, 1'b0);
        run_op(1'b1, 1'b0, 1'b1, 1'b1, 16'd8, 3'b100, 16'd5, 16'd2, 16'd0, 0, 0, 0, 1'b0, 1'b0);
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 16'd8, 3'b100, 16'd5, 16'd2, 16'd0, 0, 0, 0, 1'b0, 1'b0);
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 16'd8, 3'b100, 16'd9, 16'd2, 16'd0, 2, 0, 0, 1'b0, 1'b0);
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 3'b000, 16'hFFFF, 16'd1, 16'd0, 1, 3, 2, 1'b1, 1'b0);
        run_op(1'b1, 1'b1, 1'b1, 1'b0, 16'd0, 3'b110, 16'd7, 16'd7, 16'd7, 0, 0, 0, 1'b0, 1'b1);

        // sweep every flag and skip combination with varied stalls
        for (int idx = 0; idx < 128; idx++) begin
            run_op(idx[0], idx[1], idx[2], idx[3], W'(idx * 16'h0777 + 1), idx[6:4],
                   W'(idx * 16'h1357 + 16'hF0F0), W'(16'hFFFF - idx * 3),
                   W'(idx * 16'h0101), idx % 3, (idx / 2) % 3, (idx / 4) % 2,
                   idx[2] ^ idx[5], idx[1]);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule